// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the software-facing register file for one UART channel. A host writes and reads byte registers through a small address window. The block keeps the channel's configuration and enable state, and it turns packed command bytes into transmitter and receiver actions. It latches outgoing bytes for a serializer and gives incoming bytes from an external receive FIFO back to software. It drives a single interrupt line built from a masked set of event flags.

Two mode bytes share one address. A pointer selects between them, and each write moves the pointer on to the second byte. One command byte carries three independent fields, applied in a fixed order. Software can choose whether the receive interrupt fires on the first byte or only when the FIFO is full. Bit timing, baud generation and line error detection are handled outside this block.

Top module: `uart_regctl`

## Requirements
- R1: Only address bits 5:0 are decoded, so offset 0x44 reads the same register as 0x04. Reads of offset 0x10 and of unassigned offsets return zero. Writes to the status offset 0x04 and to unassigned offsets change no register.
- R2: Offset 0x00 reads and writes the mode byte chosen by a pointer, which starts on the first byte. Each write to 0x00 stores into the chosen byte and then points at the second byte. Reads do not move the pointer.
- R3: The status byte read at 0x04 has these bits: bit0 = FIFO level nonzero, bit1 = FIFO level equals its depth, bit2 = transmitter enabled, bit3 = no transmit byte pending. Bits 7:4 read zero.
- R4: The command byte written at 0x08 is applied in a fixed order: first the action field in bits 6:4, then the transmitter field in bits 3:2, then the receiver field in bits 1:0. Action code 1 points the mode pointer back at the first byte. Code 3 disables the transmitter and drops any pending byte. Code 5 clears the break flag. Codes 0, 4, 6 and 7 do nothing. In each enable field, 1 enables, 2 disables, and 0 or 3 do nothing.
- R5: Action code 2 disables the receiver and pulses rxf_flush for one cycle. rx_en reflects the receiver enable.
- R6: A write to 0x0C latches a transmit byte and clears status bit3. tx_valid is high while the transmitter is enabled and a byte is pending, and tx_data holds that byte. When tx_valid and tx_ready are both high at a clock edge, status bit3 is set from that edge on.
- R7: A read of 0x0C returns rxf_data and pulses rxf_pop in the same cycle when the FIFO level is nonzero. When the level is zero it returns zero and does not pop.
- R8: The interrupt status read at 0x14 has these bits: bit0 = transmitter enabled; bit1 = FIFO full when bit6 of the first mode byte is set, and level nonzero otherwise; bit2 = break flag. A write to 0x14 sets the mask. irq is high exactly when (interrupt status AND mask) is nonzero.
- R9: A one-cycle brk_in pulse sets the break flag, and the flag stays set until action code 5 clears it. When both happen in the same cycle, the set wins.
- R10: After reset the status byte reads 0x08. Both enables, both mode bytes, the mode pointer, the break flag, the mask and both baud bytes are cleared.
- R11: Offsets 0x18 and 0x1C hold two baud bytes that read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register byte address; only bits 5:0 are decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; a read of 0x0C has a side effect |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for the current address |
| tx_data | output | DW | Pending transmit byte |
| tx_valid | output | 1 | Transmit byte offered to the serializer |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| rx_en | output | 1 | Receiver enabled; gates pushes into the receive FIFO |
| rxf_pop | output | 1 | Remove the oldest byte from the receive FIFO |
| rxf_flush | output | 1 | Empty the receive FIFO |
| rxf_data | input | DW | Oldest byte in the receive FIFO (show-ahead) |
| rxf_level | input | LW | Number of bytes in the receive FIFO |
| brk_in | input | 1 | Break-change event pulse from the line receiver |
| irq | output | 1 | Level interrupt request |

## Verification
The register path is driven by a table of write and read accesses. The table covers mode pointer advance and rewind, command bytes that combine the action and enable fields, writes to read-only and unassigned offsets, and address aliasing above bit 5. These show which of the three command fields wins when they conflict. Directed sequences then fill and drain the FIFO one byte at a time. They switch the receive interrupt source between level-nonzero and full, and they hold tx_ready low and then high around a transmit byte. This separates a byte that is pending from one already handed to the serializer. They also raise a break event before and after clearing it. A mid-run reset, followed by a mode write, shows that both mode bytes and the pointer were cleared.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

    // Register offsets within the 64-byte window (address bits 5:0)
    localparam logic [5:0] OFS_MODE  = 6'h00;
    localparam logic [5:0] OFS_STAT  = 6'h04;
    localparam logic [5:0] OFS_CMD   = 6'h08;
    localparam logic [5:0] OFS_DATA  = 6'h0C;
    localparam logic [5:0] OFS_IPC   = 6'h10;
    localparam logic [5:0] OFS_INTR  = 6'h14;
    localparam logic [5:0] OFS_BAUDA = 6'h18;
    localparam logic [5:0] OFS_BAUDB = 6'h1C;

    // Bit in the first mode byte that picks FIFO-full as the receive interrupt source
    localparam int MODE_RXSEL_BIT = 6;

    // Actions decoded from one command byte
    typedef struct packed {
        logic ptr_home;
        logic rx_reset;
        logic tx_reset;
        logic brk_clear;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
    import uart_regctl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd,
    output cmd_act_t      act
);

    logic [2:0] misc_f;
    logic [1:0] tx_f;
    logic [1:0] rx_f;

    assign misc_f = cmd[6:4];
    assign tx_f   = cmd[3:2];
    assign rx_f   = cmd[1:0];

    always_comb begin
        act = '0;
        if (cmd_wr) begin
            unique case (misc_f)
                3'd1:    act.ptr_home  = 1'b1;
                3'd2:    act.rx_reset  = 1'b1;
                3'd3:    act.tx_reset  = 1'b1;
                3'd5:    act.brk_clear = 1'b1;
                default: ;
            endcase
            act.tx_on  = (tx_f == 2'd1);
            act.tx_off = (tx_f == 2'd2);
            act.rx_on  = (rx_f == 2'd1);
            act.rx_off = (rx_f == 2'd2);
        end
    end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int DW = 8
) (
    input  logic          tx_rdy,
    input  logic          rx_rdy,
    input  logic          rx_full,
    input  logic          sel_full,
    input  logic          brk_flag,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] isr,
    output logic          irq
);

    always_comb begin
        isr    = '0;
        isr[0] = tx_rdy;
        isr[1] = sel_full ? rx_full : rx_rdy;
        isr[2] = brk_flag;
    end

    assign irq = |(isr & mask);

endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter int DW         = 8,
    parameter int AW         = 8,
    parameter int FIFO_DEPTH = 4,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          rx_en,
    output logic          rxf_pop,
    output logic          rxf_flush,
    input  logic [DW-1:0] rxf_data,
    input  logic [LW-1:0] rxf_level,
    input  logic          brk_in,
    output logic          irq
);

    typedef struct packed {
        logic [DW-1:0] mode_a;
        logic [DW-1:0] mode_b;
        logic [DW-1:0] mask;
        logic [DW-1:0] baud_a;
        logic [DW-1:0] baud_b;
        logic [DW-1:0] tx_byte;
        logic          mode_sel;
        logic          tx_on;
        logic          rx_on;
        logic          tx_pend;
        logic          brk_flag;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t    st_d, st_q;
    cmd_act_t act;

    logic [5:0]    ofs;
    logic          wr_mode, wr_cmd, wr_data, wr_mask, wr_baud_a, wr_baud_b;
    logic          rx_rdy, rx_full, tx_fire;
    logic [DW-1:0] status, isr;

    assign ofs       = bus_addr[5:0];
    assign wr_mode   = bus_wr && (ofs == OFS_MODE);
    assign wr_cmd    = bus_wr && (ofs == OFS_CMD);
    assign wr_data   = bus_wr && (ofs == OFS_DATA);
    assign wr_mask   = bus_wr && (ofs == OFS_INTR);
    assign wr_baud_a = bus_wr && (ofs == OFS_BAUDA);
    assign wr_baud_b = bus_wr && (ofs == OFS_BAUDB);

    assign rx_rdy  = (rxf_level != '0);
    assign rx_full = (rxf_level == LW'(FIFO_DEPTH));

    assign tx_valid = st_q.tx_on && st_q.tx_pend;
    assign tx_data  = st_q.tx_byte;
    assign tx_fire  = tx_valid && tx_ready;
    assign rx_en    = st_q.rx_on;

    uart_cmd_dec #(.DW(DW)) i_cmd_dec (
        .cmd_wr (wr_cmd),
        .cmd    (bus_wdata),
        .act    (act)
    );

    uart_irq_gen #(.DW(DW)) i_irq_gen (
        .tx_rdy   (st_q.tx_on),
        .rx_rdy   (rx_rdy),
        .rx_full  (rx_full),
        .sel_full (st_q.mode_a[MODE_RXSEL_BIT]),
        .brk_flag (st_q.brk_flag),
        .mask     (st_q.mask),
        .isr      (isr),
        .irq      (irq)
    );

    always_comb begin
        status    = '0;
        status[0] = rx_rdy;
        status[1] = rx_full;
        status[2] = st_q.tx_on;
        status[3] = !st_q.tx_pend;
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;

        if (tx_fire) st_d.tx_pend = 1'b0;
        if (wr_data) begin
            st_d.tx_byte = bus_wdata;
            st_d.tx_pend = 1'b1;
        end

        if (wr_mode) begin
            if (st_q.mode_sel) st_d.mode_b = bus_wdata;
            else               st_d.mode_a = bus_wdata;
            st_d.mode_sel = 1'b1;
        end
        if (wr_mask)   st_d.mask   = bus_wdata;
        if (wr_baud_a) st_d.baud_a = bus_wdata;
        if (wr_baud_b) st_d.baud_b = bus_wdata;

        // Action field first
        if (act.ptr_home)  st_d.mode_sel = 1'b0;
        if (act.rx_reset)  st_d.rx_on    = 1'b0;
        if (act.tx_reset) begin
            st_d.tx_on   = 1'b0;
            st_d.tx_pend = 1'b0;
        end
        if (act.brk_clear) st_d.brk_flag = 1'b0;
        // Then transmitter field, then receiver field
        if (act.tx_on)  st_d.tx_on = 1'b1;
        if (act.tx_off) st_d.tx_on = 1'b0;
        if (act.rx_on)  st_d.rx_on = 1'b1;
        if (act.rx_off) st_d.rx_on = 1'b0;

        if (brk_in) st_d.brk_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    assign rxf_flush = act.rx_reset;
    assign rxf_pop   = bus_rd && (ofs == OFS_DATA) && rx_rdy;

    // Read mux
    always_comb begin
        unique case (ofs)
            OFS_MODE:  bus_rdata = st_q.mode_sel ? st_q.mode_b : st_q.mode_a;
            OFS_STAT:  bus_rdata = status;
            OFS_DATA:  bus_rdata = rx_rdy ? rxf_data : '0;
            OFS_INTR:  bus_rdata = isr;
            OFS_BAUDA: bus_rdata = st_q.baud_a;
            OFS_BAUDB: bus_rdata = st_q.baud_b;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk #(
    parameter int DW = 8,
    parameter int AW = 8,
    parameter int LW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          rxf_pop,
    input logic          rxf_flush,
    input logic [LW-1:0] rxf_level,
    input logic          irq,
    input logic [DW-1:0] mask,
    input logic          mode_sel
);

    logic touch_tx;
    assign touch_tx = bus_wr && ((bus_addr[5:0] == 6'h08) || (bus_addr[5:0] == 6'h0C));

    // R6: an offered byte stays offered and unchanged until accepted
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !touch_tx) |=> (tx_valid && $stable(tx_data)));

    // R7: never pop an empty FIFO
    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |-> (rxf_level != '0));

    // R5: receiver reset action produces a flush
    assert_flush_on_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[5:0] == 6'h08 && bus_wdata[6:4] == 3'd2) |-> rxf_flush);

    // R8: interrupt needs an unmasked source
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));

    // R2: a mode write leaves the pointer on the second byte
    assert_mode_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[5:0] == 6'h00) |=> mode_sel);

endmodule

bind uart_regctl uart_regctl_chk #(.DW(DW), .AW(AW), .LW(LW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rxf_pop   (rxf_pop),
    .rxf_flush (rxf_flush),
    .rxf_level (rxf_level),
    .irq       (irq),
    .mask      (st_q.mask),
    .mode_sel  (st_q.mode_sel)
);

// File: tb/test_uart_regctl.sv
module test_uart_regctl;

    localparam int DW = 8;
    localparam int AW = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] tx_data;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic          rx_en;
    logic          rxf_pop;
    logic          rxf_flush;
    logic [DW-1:0] rxf_data;
    logic [LW-1:0] rxf_level;
    logic          brk_in = 1'b0;
    logic          irq;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    uart_regctl #(.DW(DW), .AW(AW), .FIFO_DEPTH(4)) i_uart_regctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_en(rx_en), .rxf_pop(rxf_pop), .rxf_flush(rxf_flush),
        .rxf_data(rxf_data), .rxf_level(rxf_level), .brk_in(brk_in), .irq(irq)
    );

    // Behavioural receive FIFO (environment)
    logic [7:0] fm [4];
    int         fcnt = 0;
    logic       push_req = 1'b0;
    logic [7:0] push_byte = '0;

    assign rxf_data  = fm[0];
    assign rxf_level = LW'(fcnt);

    initial for (int i = 0; i < 4; i++) fm[i] = '0;

    always @(posedge clk) begin
        int n;
        n = fcnt;
        if (rxf_flush) n = 0;
        else if (rxf_pop && n > 0) begin
            for (int i = 0; i < 3; i++) fm[i] = fm[i+1];
            n = n - 1;
        end
        if (push_req && n < 4) begin
            fm[n] = push_byte;
            n = n + 1;
        end
        fcnt = n;
    end

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO? no -- FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // One bus access; for reads, compare combinational data before the edge
    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [7:0] data,
                          input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = wr;
        bus_rd    = !wr;
        #1;
        if (!wr) check(req, $sformatf("read @%h", addr), bus_rdata, exp);
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        bus_op(1'b1, addr, data, 8'h00, "");
    endtask

    task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string req);
        bus_op(1'b0, addr, 8'h00, exp, req);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        push_req  = 1'b1;
        push_byte = b;
        @(posedge clk);
        #1;
        push_req = 1'b0;
    endtask

    // {req, write, addr, data, expected}
    localparam int NV = 25;
    localparam logic [28:0] VEC [NV] = '{
        {4'd3,  1'b0, 8'h04, 8'h00, 8'h08},  // R3 status after reset
        {4'd2,  1'b1, 8'h00, 8'h40, 8'h00},  // R2 first mode byte
        {4'd2,  1'b1, 8'h00, 8'h13, 8'h00},  // R2 second mode byte
        {4'd2,  1'b0, 8'h00, 8'h00, 8'h13},  // R2 pointer advanced
        {4'd4,  1'b1, 8'h08, 8'h10, 8'h00},  // R4 rewind pointer
        {4'd4,  1'b0, 8'h00, 8'h00, 8'h40},
        {4'd8,  1'b1, 8'h14, 8'h07, 8'h00},  // R8 mask
        {4'd8,  1'b0, 8'h14, 8'h00, 8'h00},
        {4'd4,  1'b1, 8'h08, 8'h05, 8'h00},  // R4 enable both
        {4'd3,  1'b0, 8'h04, 8'h00, 8'h0C},
        {4'd8,  1'b0, 8'h14, 8'h00, 8'h01},
        {4'd6,  1'b1, 8'h0C, 8'hA5, 8'h00},  // R6 latch byte
        {4'd6,  1'b0, 8'h04, 8'h00, 8'h04},
        {4'd4,  1'b1, 8'h08, 8'h30, 8'h00},  // R4 reset tx
        {4'd4,  1'b0, 8'h04, 8'h00, 8'h08},
        {4'd4,  1'b1, 8'h08, 8'h34, 8'h00},  // R4 reset then enable
        {4'd4,  1'b0, 8'h04, 8'h00, 8'h0C},
        {4'd11, 1'b1, 8'h18, 8'h5A, 8'h00},  // R11 baud
        {4'd11, 1'b0, 8'h18, 8'h00, 8'h5A},
        {4'd11, 1'b1, 8'h1C, 8'hC3, 8'h00},
        {4'd11, 1'b0, 8'h1C, 8'h00, 8'hC3},
        {4'd1,  1'b0, 8'h10, 8'h00, 8'h00},  // R1 zero reads
        {4'd1,  1'b0, 8'h3C, 8'h00, 8'h00},
        {4'd1,  1'b1, 8'h04, 8'hFF, 8'h00},  // R1 ignored write
        {4'd1,  1'b0, 8'h44, 8'h00, 8'h0C}   // R1 alias
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        check(req, what, {7'd0, act}, {7'd0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            bus_op(VEC[v][24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0],
                   $sformatf("R%0d", VEC[v][28:25]));
        end

        // R8 masking: tx ready source unmasked then masked
        @(negedge clk);
        check_bit("R8", "irq tx source", irq, 1'b1);
        wr(8'h14, 8'h02);
        @(negedge clk);
        check_bit("R8", "irq masked", irq, 1'b0);

        // R3 R7 R8: FIFO fill with full-select mode
        push(8'h11);
        rd(8'h04, 8'h0D, "R3");
        rd(8'h14, 8'h01, "R8");
        push(8'h22); push(8'h33); push(8'h44);
        rd(8'h04, 8'h0F, "R3");
        rd(8'h14, 8'h03, "R8");
        @(negedge clk);
        check_bit("R8", "irq full", irq, 1'b1);
        rd(8'h0C, 8'h11, "R7");
        rd(8'h04, 8'h0D, "R3");
        rd(8'h0C, 8'h22, "R7");
        rd(8'h0C, 8'h33, "R7");
        rd(8'h0C, 8'h44, "R7");
        rd(8'h0C, 8'h00, "R7");
        rd(8'h04, 8'h0C, "R7");

        // R8 ready-select mode, R5 receiver reset
        wr(8'h08, 8'h10);
        wr(8'h00, 8'h00);
        push(8'h55);
        rd(8'h14, 8'h03, "R8");
        @(negedge clk);
        check_bit("R5", "rx_en on", rx_en, 1'b1);
        wr(8'h08, 8'h20);
        @(negedge clk);
        check_bit("R5", "rx_en off", rx_en, 1'b0);
        rd(8'h04, 8'h0C, "R5");
        rd(8'h14, 8'h01, "R5");

        // R6 handshake
        wr(8'h0C, 8'h3C);
        @(negedge clk);
        check_bit("R6", "tx_valid", tx_valid, 1'b1);
        check("R6", "tx_data", tx_data, 8'h3C);
        rd(8'h04, 8'h04, "R6");
        tx_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_bit("R6", "tx_valid after accept", tx_valid, 1'b0);
        tx_ready = 1'b0;
        rd(8'h04, 8'h0C, "R6");

        // R9 break flag
        @(negedge clk);
        brk_in = 1'b1;
        @(posedge clk);
        #1 brk_in = 1'b0;
        rd(8'h14, 8'h05, "R9");
        rd(8'h14, 8'h05, "R9");
        wr(8'h08, 8'h50);
        rd(8'h14, 8'h01, "R9");

        // R4 transmitter disable through its own field
        wr(8'h08, 8'h08);
        rd(8'h04, 8'h08, "R4");
        rd(8'h14, 8'h00, "R4");

        // R10 reset in the middle of operation
        wr(8'h14, 8'h07);
        wr(8'h08, 8'h05);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        rd(8'h04, 8'h08, "R10");
        rd(8'h14, 8'h00, "R10");
        rd(8'h00, 8'h00, "R10");
        rd(8'h18, 8'h00, "R10");
        @(negedge clk);
        check_bit("R10", "irq", irq, 1'b0);
        check_bit("R10", "rx_en", rx_en, 1'b0);
        wr(8'h00, 8'h21);
        rd(8'h00, 8'h00, "R10");
        wr(8'h08, 8'h10);
        rd(8'h00, 8'h21, "R10");

        finish_run();
    end

endmodule